// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches page-to-frame translations in a small, fully associative array. Each lookup compares one virtual page number and the current address-space identifier against every entry in the same cycle. On a hit it returns the physical frame number and the access-permission bits. On a miss it reports the miss, so that an outside walker can fetch the translation and install it through the fill port.

Each entry carries an address-space tag, so a context switch does not force a full invalidate. An entry marked global matches under any identifier. An entry marked wired is pinned: replacement never picks it, and neither flush command removes it. Replacement first takes the lowest-numbered free slot. Once every slot is occupied, it uses a rotating pointer that steps over pinned slots.

The lookup result is registered. It appears one clock after the request. A fill changes the array at the clock edge, so a lookup issued in the following cycle already sees the new entry.

Top module: `tlb_asid_cache`

## Requirements
- R1: After reset every entry is invalid, `res_valid` is low, and any lookup reports a miss.
- R2: A lookup presented with `lk_valid` high at a clock edge produces `res_valid` high after that edge, for exactly one cycle per request. On a hit, `res_hit` is high and `res_pfn`/`res_perm` carry the stored frame and permissions. When `res_valid` is low, all three outcome flags are low.
- R3: A lookup with no matching entry raises `res_miss` with `res_pfn` and `res_perm` zero. When `res_valid` is high, exactly one of `res_hit`, `res_miss` and `res_fault` is high.
- R4: An entry matches when it is valid, its page number equals `lk_vpn`, and either its identifier equals `lk_asid` or it is global. If several entries match, the lowest-numbered one wins.
- R5: Permission bit 0 means read allowed, bit 1 write allowed and bit 2 execute allowed. A write lookup (`lk_write`=1) that hits an entry whose bit 1 is clear raises `res_fault` instead of `res_hit`, with `res_pfn` and `res_perm` zero.
- R6: A fill takes effect at its clock edge, so a lookup in the next cycle sees it. A fill whose page number, identifier and global flag equal those of a valid entry overwrites that entry in place.
- R7: A fill that matches no entry goes into the lowest-numbered invalid slot, and the rotating pointer is left unchanged.
- R8: When every slot is valid, a fill replaces the first non-wired slot at or after the rotating pointer, wrapping around. The pointer, which is 0 after reset, then moves to the slot after the victim.
- R9: A wired entry is never chosen for replacement. When every slot is wired, a non-matching fill is dropped.
- R10: `flush_all` invalidates every non-wired entry and leaves wired entries in place.
- R11: `flush_asid_valid` invalidates only non-wired, non-global entries whose identifier equals `flush_asid`.
- R12: A flush has priority over a fill presented in the same cycle, and that fill is dropped. `flush_all` has priority over `flush_asid_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | Lookup is for a write access |
| res_valid | output | 1 | Registered lookup result present |
| res_hit | output | 1 | Translation found and access allowed |
| res_miss | output | 1 | No matching translation |
| res_fault | output | 1 | Write hit on an entry without write permission |
| res_pfn | output | PFN_W | Frame number on hit, else zero |
| res_perm | output | 3 | Permission bits on hit, else zero |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier of the installed entry |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_perm | input | 3 | Permission bits to install |
| fill_global | input | 1 | Installed entry matches any identifier |
| fill_wired | input | 1 | Installed entry is pinned |
| flush_all | input | 1 | Invalidate all non-wired entries |
| flush_asid_valid | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |

## Verification
The hardest case to reach is rotating replacement once the array is full and holds pinned slots. The pointer has to wrap past a wired slot, and the victim order then depends on the whole fill history. The stimulus fills the array completely with a wired entry in the middle, then keeps installing new pages until the pointer has passed the wired slot. After each step it sweeps every page under several identifiers against a reference model of slot occupancy kept in the bench. A separate phase pins all sixteen slots to show that a further fill is dropped.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int PERM_W     = 3;
   localparam int PERM_READ  = 0;
   localparam int PERM_WRITE = 1;
   localparam int PERM_EXEC  = 2;

   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_HIT   = 2'd1,
      RES_MISS  = 2'd2,
      RES_FAULT = 2'd3
   } res_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int N      = 16,
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8,
   parameter bit EXACT  = 1'b0
) (
   input  logic [N-1:0]      valid_i,
   input  logic [N-1:0]      glob_i,
   input  logic [VPN_W-1:0]  vpn_i  [N],
   input  logic [ASID_W-1:0] asid_i [N],
   input  logic [VPN_W-1:0]  key_vpn,
   input  logic [ASID_W-1:0] key_asid,
   input  logic              key_glob,
   output logic [N-1:0]      match_o
);
   for (genvar i = 0; i < N; i++) begin : g_ent
      logic vpn_eq;
      logic asid_eq;
      assign vpn_eq  = (vpn_i[i] == key_vpn);
      assign asid_eq = (asid_i[i] == key_asid);
      if (EXACT) begin : g_exact
         // tag identity, used to detect a refill of an existing entry
         assign match_o[i] = valid_i[i] & vpn_eq & (glob_i[i] == key_glob)
                             & (glob_i[i] | asid_eq);
      end else begin : g_assoc
         // lookup compare: global entries ignore the identifier
         assign match_o[i] = valid_i[i] & vpn_eq & (glob_i[i] | key_glob | asid_eq);
      end
   end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
   parameter int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            found_o = 1'b1;
            idx_o   = IW'(k);
         end
      end
   end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  valid_i,
   input  logic [N-1:0]  wired_i,
   input  logic [IW-1:0] ptr_i,
   output logic          ok_o,
   output logic          evict_o,
   output logic [IW-1:0] idx_o
);
   logic          free_found;
   logic [IW-1:0] free_idx;
   logic          rr_found;
   logic [IW-1:0] rr_idx;

   tlb_prio_enc #(.N(N)) u_free (
      .req_i   (~valid_i & ~wired_i),
      .found_o (free_found),
      .idx_o   (free_idx)
   );

   always_comb begin
      logic [IW-1:0] cand;
      rr_found = 1'b0;
      rr_idx   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         cand = ptr_i + IW'(k);
         if (!wired_i[cand]) begin
            rr_found = 1'b1;
            rr_idx   = cand;
         end
      end
   end

   assign ok_o    = free_found | rr_found;
   assign evict_o = ~free_found & rr_found;
   assign idx_o   = free_found ? free_idx : rr_idx;
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 16,
   parameter int ASID_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lk_valid,
   input  logic [VPN_W-1:0]    lk_vpn,
   input  logic [ASID_W-1:0]   lk_asid,
   input  logic                lk_write,
   output logic                res_valid,
   output logic                res_hit,
   output logic                res_miss,
   output logic                res_fault,
   output logic [PFN_W-1:0]    res_pfn,
   output logic [PERM_W-1:0]   res_perm,
   input  logic                fill_valid,
   input  logic [VPN_W-1:0]    fill_vpn,
   input  logic [ASID_W-1:0]   fill_asid,
   input  logic [PFN_W-1:0]    fill_pfn,
   input  logic [PERM_W-1:0]   fill_perm,
   input  logic                fill_global,
   input  logic                fill_wired,
   input  logic                flush_all,
   input  logic                flush_asid_valid,
   input  logic [ASID_W-1:0]   flush_asid
);
   localparam int IW = $clog2(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two, at least 2");
   end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   logic [VPN_W-1:0]  ent_vpn  [ENTRIES];
   logic [ASID_W-1:0] ent_asid [ENTRIES];
   logic [PFN_W-1:0]  ent_pfn  [ENTRIES];
   logic [PERM_W-1:0] ent_perm [ENTRIES];
   logic [ENTRIES-1:0] ent_valid;
   logic [ENTRIES-1:0] ent_glob;
   logic [ENTRIES-1:0] ent_wired;
   logic [IW-1:0]      rr_ptr;

   logic [ENTRIES-1:0] lk_match;
   logic               lk_found;
   logic [IW-1:0]      lk_idx;
   logic [ENTRIES-1:0] same_match;
   logic               same_found;
   logic [IW-1:0]      same_idx;
   logic               vic_ok;
   logic               vic_evict;
   logic [IW-1:0]      vic_idx;
   logic               fill_go;
   logic [IW-1:0]      fill_tgt;

   res_kind_e          res_kind;

   tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .EXACT(1'b0)) u_lk_match (
      .valid_i  (ent_valid),
      .glob_i   (ent_glob),
      .vpn_i    (ent_vpn),
      .asid_i   (ent_asid),
      .key_vpn  (lk_vpn),
      .key_asid (lk_asid),
      .key_glob (1'b0),
      .match_o  (lk_match)
   );

   tlb_prio_enc #(.N(ENTRIES)) u_lk_enc (
      .req_i   (lk_match),
      .found_o (lk_found),
      .idx_o   (lk_idx)
   );

   tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .EXACT(1'b1)) u_fill_match (
      .valid_i  (ent_valid),
      .glob_i   (ent_glob),
      .vpn_i    (ent_vpn),
      .asid_i   (ent_asid),
      .key_vpn  (fill_vpn),
      .key_asid (fill_asid),
      .key_glob (fill_global),
      .match_o  (same_match)
   );

   tlb_prio_enc #(.N(ENTRIES)) u_fill_enc (
      .req_i   (same_match),
      .found_o (same_found),
      .idx_o   (same_idx)
   );

   tlb_victim #(.N(ENTRIES)) u_victim (
      .valid_i (ent_valid),
      .wired_i (ent_wired),
      .ptr_i   (rr_ptr),
      .ok_o    (vic_ok),
      .evict_o (vic_evict),
      .idx_o   (vic_idx)
   );

   assign fill_go  = fill_valid & ~flush_all & ~flush_asid_valid & (same_found | vic_ok);
   assign fill_tgt = same_found ? same_idx : vic_idx;

   // array state: flush beats fill
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_valid <= '0;
         ent_glob  <= '0;
         ent_wired <= '0;
         rr_ptr    <= '0;
      end else if (flush_all) begin
         ent_valid <= ent_valid & ent_wired;
      end else if (flush_asid_valid) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (!ent_wired[i] && !ent_glob[i] && ent_asid[i] == flush_asid) begin
               ent_valid[i] <= 1'b0;
            end
         end
      end else if (fill_go) begin
         ent_valid[fill_tgt] <= 1'b1;
         ent_glob[fill_tgt]  <= fill_global;
         ent_wired[fill_tgt] <= fill_wired;
         if (!same_found && vic_evict) begin
            rr_ptr <= vic_idx + IW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_go) begin
         ent_vpn[fill_tgt]  <= fill_vpn;
         ent_asid[fill_tgt] <= fill_asid;
         ent_pfn[fill_tgt]  <= fill_pfn;
         ent_perm[fill_tgt] <= fill_perm;
      end
   end

   // registered lookup result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_kind  <= RES_NONE;
         res_pfn   <= '0;
         res_perm  <= '0;
      end else begin
         res_valid <= lk_valid;
         res_pfn   <= '0;
         res_perm  <= '0;
         if (!lk_valid) begin
            res_kind <= RES_NONE;
         end else if (!lk_found) begin
            res_kind <= RES_MISS;
         end else if (lk_write && !ent_perm[lk_idx][PERM_WRITE]) begin
            res_kind <= RES_FAULT;
         end else begin
            res_kind <= RES_HIT;
            res_pfn  <= ent_pfn[lk_idx];
            res_perm <= ent_perm[lk_idx];
         end
      end
   end

   assign res_hit   = (res_kind == RES_HIT);
   assign res_miss  = (res_kind == RES_MISS);
   assign res_fault = (res_kind == RES_FAULT);
endmodule

// File: rtl/tlb_asid_cache_chk.sv
module tlb_asid_cache_chk #(
   parameter int PFN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             lk_write,
   input logic             res_valid,
   input logic             res_hit,
   input logic             res_miss,
   input logic             res_fault,
   input logic [PFN_W-1:0] res_pfn,
   input logic [2:0]       res_perm
);
   AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);                                              // R2
   AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);                                            // R2
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !(res_hit || res_miss || res_fault));                  // R2
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $countones({res_hit, res_miss, res_fault}) == 1);       // R3
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      res_miss |-> (res_pfn == '0 && res_perm == '0));                      // R3
   AST_FAULT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault |-> $past(lk_write));                                       // R5
   AST_WRITE_HIT_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
      (res_hit && $past(lk_write)) |-> res_perm[1]);                        // R5
endmodule

bind tlb_asid_cache tlb_asid_cache_chk #(.PFN_W(PFN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_valid  (lk_valid),
   .lk_write  (lk_write),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_miss  (res_miss),
   .res_fault (res_fault),
   .res_pfn   (res_pfn),
   .res_perm  (res_perm)
);

// File: tb/tlb_asid_cache_test.sv
module tlb_asid_cache_test;
   localparam int N      = 16;
   localparam int VPN_W  = 20;
   localparam int PFN_W  = 16;
   localparam int ASID_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_valid = 1'b0, lk_write = 1'b0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic [ASID_W-1:0] lk_asid = '0;
   logic res_valid, res_hit, res_miss, res_fault;
   logic [PFN_W-1:0] res_pfn;
   logic [2:0] res_perm;
   logic fill_valid = 1'b0, fill_global = 1'b0, fill_wired = 1'b0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [ASID_W-1:0] fill_asid = '0;
   logic [PFN_W-1:0] fill_pfn = '0;
   logic [2:0] fill_perm = '0;
   logic flush_all = 1'b0, flush_asid_valid = 1'b0;
   logic [ASID_W-1:0] flush_asid = '0;

   int checks = 0;
   int fails = 0;

   // reference model state
   bit        m_valid [N];
   bit        m_glob  [N];
   bit        m_wired [N];
   int        m_vpn   [N];
   int        m_asid  [N];
   int        m_pfn   [N];
   int        m_perm  [N];
   int        m_ptr;

   always #2.5 clk = ~clk;

   tlb_asid_cache #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_write(lk_write),
      .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
      .res_pfn(res_pfn), .res_perm(res_perm),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
      .fill_perm(fill_perm), .fill_global(fill_global), .fill_wired(fill_wired),
      .flush_all(flush_all), .flush_asid_valid(flush_asid_valid), .flush_asid(flush_asid)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 0; m_glob[i] = 0; m_wired[i] = 0;
      end
      m_ptr = 0;
   endtask

   function automatic logic [63:0] model_lookup(int vpn, int asid, bit wr);
      for (int i = 0; i < N; i++) begin
         if (m_valid[i] && m_vpn[i] == vpn && (m_glob[i] || m_asid[i] == asid)) begin
            if (wr && m_perm[i][1] == 1'b0) return {3'b001, 16'h0, 3'b000};
            return {3'b100, m_pfn[i][15:0], m_perm[i][2:0]};
         end
      end
      return {3'b010, 16'h0, 3'b000};
   endfunction

   function automatic void model_fill(int vpn, int asid, int pfn, int perm, bit g, bit w);
      int t = -1;
      for (int i = 0; i < N && t < 0; i++)
         if (m_valid[i] && m_vpn[i] == vpn && m_glob[i] == g && (g || m_asid[i] == asid)) t = i;
      if (t < 0)
         for (int i = 0; i < N && t < 0; i++)
            if (!m_valid[i] && !m_wired[i]) t = i;
      if (t < 0) begin
         for (int k = 0; k < N && t < 0; k++)
            if (!m_wired[(m_ptr + k) % N]) t = (m_ptr + k) % N;
         if (t >= 0) m_ptr = (t + 1) % N;
      end
      if (t < 0) return;
      m_valid[t] = 1; m_glob[t] = g; m_wired[t] = w;
      m_vpn[t] = vpn; m_asid[t] = asid; m_pfn[t] = pfn; m_perm[t] = perm;
   endfunction

   task automatic lookup(string tag, int vpn, int asid, bit wr);
      logic [63:0] exp;
      exp = model_lookup(vpn, asid, wr);
      lk_valid = 1'b1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); lk_write = wr;
      @(posedge clk);
      @(negedge clk);
      lk_valid = 1'b0;
      check(tag, {40'h0, res_valid, res_hit, res_miss, res_fault, res_pfn, res_perm},
            {40'h0, 1'b1, exp[21:0]});
   endtask

   task automatic fill(int vpn, int asid, int pfn, int perm, bit g, bit w);
      fill_valid = 1'b1; fill_vpn = VPN_W'(vpn); fill_asid = ASID_W'(asid);
      fill_pfn = PFN_W'(pfn); fill_perm = 3'(perm); fill_global = g; fill_wired = w;
      @(posedge clk);
      model_fill(vpn, asid, pfn, perm, g, w);
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic sweep(string tag, int lo, int hi);
      for (int v = lo; v <= hi; v++)
         for (int a = 1; a <= 3; a++)
            for (int w = 0; w < 2; w++)
               lookup(tag, v, a, w[0]);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic int perm_of(int i);
      return (i % 3 == 0) ? 1 : ((i % 3 == 1) ? 3 : 7);
   endfunction

   initial begin
      #(5ns * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R1: empty after reset
      check("R1 res_valid idle", {63'h0, res_valid}, 64'h0);
      sweep("R1 miss after reset", 'h10, 'h13);

      // R7 fill free slots; R2 R3 R4 R5 sweep, slot 7 global
      for (int i = 0; i < 8; i++) fill('h10 + i, 1, 'h100 + i, perm_of(i), i == 7, 0);
      lookup("R6 fill seen next cycle", 'h17, 2, 0);
      sweep("R2 R4 R5 lookup sweep", 'h10, 'h18);
      // R4 lowest index wins: private entry beside the global one
      fill('h17, 2, 'h777, 7, 0, 0);
      lookup("R4 priority", 'h17, 2, 1);

      // slot 9 wired, rest fill; array full
      fill('h20, 1, 'h200, 3, 0, 1);
      for (int i = 0; i < 6; i++) fill('h21 + i, 1, 'h210 + i, perm_of(i), 0, 0);
      sweep("R7 full array", 'h10, 'h26);

      // R8 round robin eviction, pointer wraps past wired slot 9
      for (int i = 0; i < 12; i++) begin
         fill('h30 + i, 1, 'h300 + i, 3, 0, 0);
         lookup("R8 new entry", 'h30 + i, 1, 1);
      end
      sweep("R8 R9 after eviction", 'h10, 'h3b);

      // R6 overwrite in place
      fill('h3b, 1, 'h5b5, 7, 0, 0);
      sweep("R6 overwrite", 'h30, 'h3b);

      // R11 flush by identifier
      fill('h40, 2, 'h400, 3, 0, 0);
      fill('h41, 3, 'h410, 3, 0, 0);
      flush_asid_valid = 1'b1; flush_asid = 8'd1;
      @(posedge clk);
      for (int i = 0; i < N; i++)
         if (!m_wired[i] && !m_glob[i] && m_asid[i] == 1) m_valid[i] = 0;
      @(negedge clk);
      flush_asid_valid = 1'b0;
      sweep("R11 flush asid", 'h10, 'h41);

      // R12 flush beats fill
      flush_all = 1'b1; fill_valid = 1'b1; fill_vpn = 'h50; fill_asid = 1;
      fill_pfn = 'h500; fill_perm = 3; fill_global = 0; fill_wired = 0;
      @(posedge clk);
      for (int i = 0; i < N; i++) if (!m_wired[i]) m_valid[i] = 0;
      @(negedge clk);
      flush_all = 1'b0; fill_valid = 1'b0;
      lookup("R12 fill dropped", 'h50, 1, 0);
      // R10 only wired survives
      sweep("R10 flush all", 'h10, 'h41);

      // R9 all wired: extra fill dropped
      do_reset();
      for (int i = 0; i < N; i++) fill('h60 + i, 4, 'h600 + i, 3, 0, 1);
      fill('h80, 4, 'h800, 3, 0, 0);
      lookup("R9 all wired drop", 'h80, 4, 0);
      for (int i = 0; i < N; i++) lookup("R9 wired kept", 'h60 + i, 4, 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule